// File: doc/BRIEF.md
# Voltage-Identification Code Filter and Reference Selector

This block sits between four pad-level voltage-identification pins and the reference DAC of a buck regulator. Each pin is brought into the core clock domain through its own two-stage synchroniser. A change of the code is accepted only once all four synchronised bits have held one value for a programmable number of clock cycles. Because the bits of an external code rarely switch at the same instant, this hold window stops the DAC from ever being loaded with a half-updated code.

A status input from the start-up sequencer chooses what the DAC receives. While that input is low, the block sends the all-ones default code, which sets the highest reference. The sequencer holds the input low during soft-start, and again after an enable toggle, a power cycle or a restart after a short-circuit fault. Once soft-start has finished, the block forwards the filtered live code.

Alongside the code, the block drives the matching reference level in millivolts, which is 900 mV plus 20 mV per code step. It also drives a one-cycle strobe each time the code it sends changes.

Top module: `vid_ref_manager`

## Requirements
- R1: `ref_mv` always equals 900 + 20 × `code_out`, read as an unsigned value. Code 0000 gives 900 and code 1111 gives 1200.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `code_out` is 1111, `ref_mv` is 1200 and `code_chg` is 0.
- R3: For every clock edge at which `ss_done` is sampled low, `code_out` is 1111 after that edge, whatever the `vid_pins` are.
- R4: For every clock edge at which `ss_done` is sampled high, `code_out` after that edge equals the filtered code as it stood before that edge.
- R5: Call the first clock edge that samples a new steady `vid_pins` value edge 0. The filtered code takes that value at edge FILT_CYC+2. With `ss_done` high, `code_out` shows it after edge FILT_CYC+3.
- R6: The hold count restarts whenever any single bit changes. A value that lasts for fewer than FILT_CYC+1 synchronised samples, including a transitional code seen while the bits change one at a time, never reaches `code_out`.
- R7: `code_chg` is high for exactly the cycles in which `code_out` differs from its value in the previous cycle. This includes changes caused by `ss_done` forcing or releasing the default.
- R8: When `ss_done` falls and then rises again, `code_out` goes back to the filtered code on the edge after the rise, without a new hold window, as long as the pins stayed steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_pins | input | 4 | Asynchronous voltage-identification inputs, bit 3 most significant |
| ss_done | input | 1 | High once soft-start has completed; low forces the default code |
| code_out | output | 4 | Validated code sent to the reference DAC |
| ref_mv | output | 11 | Reference level of `code_out` in millivolts |
| code_chg | output | 1 | One-cycle pulse when `code_out` changes |

## Verification
The bench targets the exact acceptance edge of a new code. A counter that is off by one would move `code_out` a cycle early or late, and the per-cycle comparison would flag that cycle.

It drives a short glitch that ends one sample before the window closes, and a bit-by-bit skewed change whose intermediate codes each last only a few cycles. A filter that did not restart on every bit change would pass one of those intermediate codes to the DAC.

It lowers `ss_done` in the middle of operation. A design that forgets to force the default, or that restarts the filter on release, would show the wrong code for up to a full window. It also runs all sixteen codes so that any slip in the millivolt decode is caught.

// File: rtl/vid_ref_pkg.sv
// Package: shared widths, the default code and the millivolt decode.
// Assumes a 4-bit code whose levels are evenly spaced.
package vid_ref_pkg;
    localparam int CODE_W   = 4;
    localparam int MV_W     = 11;
    localparam int BASE_MV  = 900;
    localparam int STEP_MV  = 20;
    localparam logic [CODE_W-1:0] DEFAULT_CODE = '1;

    // Convert a code into its reference level in millivolts.
    function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] c);
        int v;
        v = BASE_MV + STEP_MV * int'(c);
        return v[MV_W-1:0];
    endfunction
endpackage

// File: rtl/vid_sync.sv
// vid_sync: a two-flop synchroniser for each input bit.
// Assumes the inputs idle high (pulled up), so the flops reset to 1.
module vid_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Two flops in series bring bit b into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b1;
                d_sync[b] <= 1'b1;
            end else begin
                meta_q[b] <= d_async[b];
                d_sync[b] <= meta_q[b];
            end
        end
    end
endmodule

// File: rtl/vid_deglitch.sv
// vid_deglitch: accepts a synchronised code only after it has held steady.
// The code is accepted once it has been seen for FILT_CYC+1 samples in a row,
// and any change of any bit starts the count again.
// Assumes FILT_CYC >= 1.
module vid_deglitch
    import vid_ref_pkg::*;
#(
    parameter int FILT_CYC = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] d_sync,
    output logic [CODE_W-1:0] filt_code
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(FILT_CYC - 1);

    logic [CODE_W-1:0] cand_q;
    logic [CNT_W-1:0]  cnt_q;

    // Track the candidate code, count how long it has held, and accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= DEFAULT_CODE;
            cnt_q     <= '0;
            filt_code <= DEFAULT_CODE;
        end else if (d_sync != cand_q) begin
            cand_q <= d_sync;
            cnt_q  <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            filt_code <= cand_q;
        end
    end

    // R6: the hold counter never runs past its limit.
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R5: the accepted code changes only once a full hold has built up.
    a_r5_hold_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_code != $past(filt_code)) |-> ($past(cnt_q) == LIM));

    // R6: a bit change in the window keeps the accepted code where it was.
    a_r6_change_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (d_sync != cand_q) |=> $stable(filt_code));
endmodule

// File: rtl/vid_select.sv
// vid_select: picks the forced default or the filtered code, registers it,
// and flags changes. Assumes ss_done is already synchronous to clk.
module vid_select
    import vid_ref_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_done,
    input  logic [CODE_W-1:0] filt_code,
    output logic [CODE_W-1:0] code_q,
    output logic              chg_q
);
    logic [CODE_W-1:0] next_code;

    // Choose the default during start-up and the live code afterwards.
    always_comb next_code = ss_done ? filt_code : DEFAULT_CODE;

    // Register the chosen code and pulse when it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= DEFAULT_CODE;
            chg_q  <= 1'b0;
        end else begin
            code_q <= next_code;
            chg_q  <= (next_code != code_q);
        end
    end

    // R3: while start-up is in progress the default is forced.
    a_r3_forced_default: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> (code_q == DEFAULT_CODE));

    // R4: after soft-start the filtered code is forwarded.
    a_r4_follow_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |=> (code_q == $past(filt_code)));

    // R7: the strobe marks a change of the output code.
    a_r7_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (code_q != $past(code_q)));

    // R7: an unchanged code raises no strobe.
    a_r7_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(code_q) |-> !chg_q);
endmodule

// File: rtl/vid_ref_manager.sv
// vid_ref_manager: top level. Synchronises the pins, filters them against
// bit skew, applies the start-up default and decodes the reference level.
// Assumes vid_pins may change at any time and ss_done comes from the clk domain.
module vid_ref_manager
    import vid_ref_pkg::*;
#(
    parameter int FILT_CYC = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vid_pins,
    input  logic              ss_done,
    output logic [CODE_W-1:0] code_out,
    output logic [MV_W-1:0]   ref_mv,
    output logic              code_chg
);
    logic [CODE_W-1:0] sync_code;
    logic [CODE_W-1:0] filt_code;

    vid_sync #(.W(CODE_W)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(vid_pins), .d_sync(sync_code)
    );

    vid_deglitch #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk(clk), .rst_n(rst_n), .d_sync(sync_code), .filt_code(filt_code)
    );

    vid_select sel_i (
        .clk(clk), .rst_n(rst_n), .ss_done(ss_done), .filt_code(filt_code),
        .code_q(code_out), .chg_q(code_chg)
    );

    // Decode the registered code into millivolts for the reference level.
    always_comb ref_mv = code_to_mv(code_out);

    // R1: the reference stays inside the decoded span.
    a_r1_mv_span: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_mv >= MV_W'(BASE_MV)) && (ref_mv <= MV_W'(BASE_MV + 15 * STEP_MV)));
endmodule

// File: tb/vid_ref_manager_tb_top.sv
module vid_ref_manager_tb_top;
    localparam int FILT = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] vid_pins = 4'hF;
    logic       ss_done = 1'b0;
    logic [3:0] code_out;
    logic [10:0] ref_mv;
    logic       code_chg;

    int checks = 0;
    int errors = 0;
    string tag = "R2";
    bit started = 0;
    bit done = 0;

    // Behavioural reference model state.
    int q_in[$];
    int prev_v = 15;
    int run = 1;
    int m_filt = 15;
    int m_code = 15;
    int m_chg = 0;

    always #10 clk = ~clk;

    vid_ref_manager #(.FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .vid_pins(vid_pins), .ss_done(ss_done),
        .code_out(code_out), .ref_mv(ref_mv), .code_chg(code_chg)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", rq, $time, act, exp);
        end
    endtask

    // Model: a value is accepted once seen for FILT+1 samples in a row, two samples late.
    always @(posedge clk) begin
        int v, nc;
        started = 1;
        if (!rst_n) begin
            q_in = '{15, 15};
            prev_v = 15; run = 1; m_filt = 15; m_code = 15; m_chg = 0;
        end else begin
            nc = ss_done ? m_filt : 15;
            m_chg = (nc != m_code);
            m_code = nc;
            q_in.push_back(int'(vid_pins));
            v = q_in[q_in.size()-3];
            if (q_in.size() > 3) void'(q_in.pop_front());
            if (v == prev_v) run++; else run = 1;
            prev_v = v;
            if (run >= FILT + 1) m_filt = v;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(code_out == 4'(m_code), tag, int'(code_out), m_code);
            check(int'(ref_mv) == 900 + 20 * m_code, "R1", int'(ref_mv), 900 + 20 * m_code);
            check(int'(code_chg) == m_chg, "R7", int'(code_chg), m_chg);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(4);
        // R2: reset state.
        check(code_out == 4'hF && ref_mv == 11'd1200 && !code_chg, "R2",
              int'(ref_mv), 1200);
        rst_n = 1'b1;
        // R3: pins ignored while the default is forced.
        tag = "R3";
        vid_pins = 4'h5;
        cyc(60);
        check(code_out == 4'hF, "R3", int'(code_out), 15);
        // R4: release forwards the already filtered code.
        tag = "R4";
        ss_done = 1'b1;
        cyc(2);
        check(code_out == 4'h5, "R4", int'(code_out), 5);
        // R5: exact acceptance edge.
        tag = "R5";
        vid_pins = 4'h0;
        cyc(FILT + 3);
        check(code_out == 4'h5, "R5", int'(code_out), 5);
        cyc(1);
        check(code_out == 4'h0, "R5", int'(code_out), 0);
        cyc(10);
        // R6: a glitch that ends one sample short of acceptance.
        tag = "R6";
        vid_pins = 4'hA;
        cyc(FILT);
        vid_pins = 4'h0;
        cyc(FILT + 10);
        check(code_out == 4'h0, "R6", int'(code_out), 0);
        // R6: skewed change toward 0011, one bit at a time.
        vid_pins = 4'h1; cyc(5);
        vid_pins = 4'h3; cyc(FILT + 6);
        check(code_out == 4'h3, "R6", int'(code_out), 3);
        // R8: drop and restore the start-up status.
        tag = "R8";
        ss_done = 1'b0;
        cyc(10);
        check(code_out == 4'hF, "R8", int'(code_out), 15);
        ss_done = 1'b1;
        cyc(1);
        check(code_out == 4'h3, "R8", int'(code_out), 3);
        // R1: sweep all sixteen codes.
        tag = "R5";
        for (int c = 0; c < 16; c++) begin
            vid_pins = 4'(c);
            cyc(FILT + 8);
            check(int'(ref_mv) == 900 + 20 * c, "R1", int'(ref_mv), 900 + 20 * c);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule